// File: doc/BRIEF.md
# Oscillator Seconds Prescaler with Digital Time Trim

This block turns a crystal-rate enable strobe into a one-cycle seconds tick, and digitally compensates crystal frequency error. It counts oscillator enables and emits a tick each time the count reaches the division modulus. Once per adjustment window the last second of the window is made shorter or longer by a programmed number of oscillator counts. A fast crystal can be slowed down and a slow one sped up, without touching the analog part.

The correction comes from an 8-bit trim value written through a simple write strobe. Bits 5:0 are an offset-coded count field, bit 6 chooses the direction and bit 7 is a mode bit. Its meaning depends on the build variant. On the fine variant it stretches the window by a factor, so each step is worth fewer ppb. On the crystal variant it selects an alternate crystal frequency, and the division modulus follows that crystal. A written value waits in a staging register and becomes active only at the next window boundary, so a window never mixes two trim settings.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: `sec_tick` is high for exactly one clock cycle per completed division and is low while `rst_n` is low and in the first cycle after it.
- R2: With no adjustment in force, each second spans exactly BASE accepted oscillator counts. BASE is `OSC_HZ`, or `ALT_HZ` where R8 applies. A cycle with `osc_en` low does not advance the count. After reset the active trim is 0x00.
- R3: When trim bits 5:1 are all zero the adjustment is zero, whatever bit 0 and bit 6 hold (for example 0x00, 0x01, 0x40 and 0x41).
- R4: With bit 6 clear and field F = bits 5:0 in 2..63, the last second of the window is shortened by `STEP_CNT*(F-1)` counts.
- R5: With bit 6 set and F in 2..63, the last second of the window is lengthened by `STEP_CNT*(((~F)&63)+1)` counts. For example 0x7F gives 1 step and 0x42 gives 62 steps.
- R6: Every second of a window other than its last spans exactly BASE counts, whatever the trim.
- R7: On the fine variant (`CRYSTAL_SEL`=0), trim bit 7 set makes the window `WIN_SECS*FINE_MULT` seconds long. BASE stays `OSC_HZ`. With bit 7 clear the window is `WIN_SECS` seconds.
- R8: On the crystal variant (`CRYSTAL_SEL`=1), trim bit 7 set makes BASE equal to `ALT_HZ`. The window stays `WIN_SECS` seconds long.
- R9: A trim write goes into a staging register. It is used from the window that starts after the next window boundary, and a write made partway through a window does not change that window. The window count restarts at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One pulse per crystal period |
| trim_we | input | 1 | Trim write strobe |
| trim_wdata | input | 8 | Trim value to stage |
| sec_tick | output | 1 | One-cycle seconds tick |

## Verification
The bench builds two instances from the same stimulus. Both use `OSC_HZ`=150, `ALT_HZ`=140, `WIN_SECS`=3, `FINE_MULT`=2 and `STEP_CNT`=2, one with `CRYSTAL_SEL`=0 and the other with `CRYSTAL_SEL`=1. These small moduli still exceed the largest adjustment of 124 counts. The full plus and minus 62-step range, the no-adjust zone, both meanings of bit 7 and staged writes partway through a window therefore each fit in a few thousand cycles. Because `osc_en` is randomly gapped, the bench also shows that the division counts crystal periods and not clock cycles.

// File: rtl/rtc_trim_pkg.sv
// Shared types and trim decoding for the seconds prescaler.
// Assumes an 8-bit trim word: mode bit, direction bit, 6-bit offset-coded field.
package rtc_trim_pkg;

    typedef struct packed {
        logic       mode;   // bit 7: fine window or alternate crystal
        logic       dec;    // bit 6: lengthen instead of shorten
        logic [5:0] field;  // bits 5:0: offset-coded step count
    } trim_t;

    typedef struct packed {
        logic       neg;    // 1: lengthen the last second
        logic [5:0] mag;    // step count, 0..62
    } steps_t;

    // Convert a trim word into a direction and a step magnitude.
    function automatic steps_t trim_steps(input trim_t t);
        steps_t s;
        s = '0;
        if (t.field[5:1] != 5'd0) begin
            if (!t.dec) begin
                s.neg = 1'b0;
                s.mag = t.field - 6'd1;
            end else begin
                s.neg = 1'b1;
                s.mag = (~t.field) + 6'd1;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/rtc_trim_decode.sv
// Turns the active trim word into the base modulus, the window length and
// the shorten/lengthen counts. It is purely combinational. It assumes
// OSC_HZ and ALT_HZ each exceed 62*STEP_CNT+1.
module rtc_trim_decode
    import rtc_trim_pkg::*;
#(
    parameter int OSC_HZ      = 32768,
    parameter int ALT_HZ      = 32000,
    parameter int WIN_SECS    = 20,
    parameter int FINE_MULT   = 3,
    parameter int STEP_CNT    = 2,
    parameter bit CRYSTAL_SEL = 1'b0,
    parameter int CNT_W       = 16,
    parameter int ADJ_W       = 7,
    parameter int SEC_W       = 6
) (
    input  trim_t             trim,
    output logic [CNT_W-1:0]  base_mod,
    output logic [SEC_W-1:0]  win_len,
    output logic [ADJ_W-1:0]  shorten_cnt,
    output logic [ADJ_W-1:0]  lengthen_cnt
);

    steps_t             st;
    logic [ADJ_W-1:0]   adj_cnt;

    // Step count scaled to oscillator counts.
    always_comb begin
        st      = trim_steps(trim);
        adj_cnt = ADJ_W'(st.mag) * ADJ_W'(STEP_CNT);
        shorten_cnt  = st.neg ? '0 : adj_cnt;
        lengthen_cnt = st.neg ? adj_cnt : '0;
    end

    // The build variant decides what the mode bit means.
    generate
        if (CRYSTAL_SEL) begin : g_xtal
            assign base_mod = trim.mode ? CNT_W'(ALT_HZ) : CNT_W'(OSC_HZ);
            assign win_len  = SEC_W'(WIN_SECS);
        end else begin : g_fine
            assign base_mod = CNT_W'(OSC_HZ);
            assign win_len  = trim.mode ? SEC_W'(WIN_SECS * FINE_MULT)
                                        : SEC_W'(WIN_SECS);
        end
    endgenerate

endmodule

// File: rtl/rtc_trim_window.sv
// Counts seconds inside the adjustment window. It flags the last second
// and moves the staged trim into the active trim at each window boundary.
// It assumes wrap pulses once per completed second.
module rtc_trim_window
    import rtc_trim_pkg::*;
#(
    parameter int SEC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  trim_t             staged_trim,
    input  logic [SEC_W-1:0]  win_len,
    output trim_t             active_trim,
    output logic              last_sec
);

    logic [SEC_W-1:0] sec_q;

    assign last_sec = (sec_q == win_len - SEC_W'(1));

    // Advance the second index; at the boundary restart and load the trim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q       <= '0;
            active_trim <= '0;
        end else if (wrap) begin
            if (last_sec) begin
                sec_q       <= '0;
                active_trim <= staged_trim;
            end else begin
                sec_q <= sec_q + SEC_W'(1);
            end
        end
    end

    AST_SEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q < win_len);                                            // R6
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(active_trim));                             // R9

endmodule

// File: rtl/rtc_trim_divider.sv
// Counts oscillator enables up to a per-second modulus. The modulus is
// the base value, adjusted by the trim counts in the last second of a
// window. It flags the wrap and registers a one-cycle tick.
module rtc_trim_divider #(
    parameter int CNT_W = 16,
    parameter int ADJ_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [CNT_W-1:0]  base_mod,
    input  logic [ADJ_W-1:0]  shorten_cnt,
    input  logic [ADJ_W-1:0]  lengthen_cnt,
    input  logic              last_sec,
    output logic              wrap,
    output logic              tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_len;

    // Length of the current second in oscillator counts.
    always_comb begin
        mod_len = base_mod;
        if (last_sec)
            mod_len = base_mod + CNT_W'(lengthen_cnt) - CNT_W'(shorten_cnt);
    end

    assign wrap = osc_en && (cnt_q == mod_len - CNT_W'(1));

    // Oscillator count within the second, plus the registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= wrap;
            if (wrap)
                cnt_q <= '0;
            else if (osc_en)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                             // R1
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < mod_len);                                            // R2

endmodule

// File: rtl/rtc_trim_prescaler.sv
// Top of the trimmed seconds prescaler. It stages trim writes, tracks
// the adjustment window and divides the oscillator enable to a seconds
// tick. It assumes osc_en is a single-cycle strobe at the crystal rate.
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int OSC_HZ      = 32768,
    parameter int ALT_HZ      = 32000,
    parameter int WIN_SECS    = 20,
    parameter int FINE_MULT   = 3,
    parameter int STEP_CNT    = 2,
    parameter bit CRYSTAL_SEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       trim_we,
    input  logic [7:0] trim_wdata,
    output logic       sec_tick
);

    localparam int MAX_ADJ = 62 * STEP_CNT;
    localparam int MAX_HZ  = (OSC_HZ > ALT_HZ) ? OSC_HZ : ALT_HZ;
    localparam int CNT_W   = $clog2(MAX_HZ + MAX_ADJ + 1);
    localparam int ADJ_W   = $clog2(MAX_ADJ + 1);
    localparam int SEC_W   = $clog2(WIN_SECS * FINE_MULT + 1);

    trim_t             staged_q;
    trim_t             active_trim;
    logic [CNT_W-1:0]  base_mod;
    logic [SEC_W-1:0]  win_len;
    logic [ADJ_W-1:0]  shorten_cnt;
    logic [ADJ_W-1:0]  lengthen_cnt;
    logic              last_sec;
    logic              wrap;

    // Staging register for software trim writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            staged_q <= '0;
        else if (trim_we)
            staged_q <= trim_t'(trim_wdata);
    end

    rtc_trim_decode #(
        .OSC_HZ(OSC_HZ), .ALT_HZ(ALT_HZ), .WIN_SECS(WIN_SECS),
        .FINE_MULT(FINE_MULT), .STEP_CNT(STEP_CNT),
        .CRYSTAL_SEL(CRYSTAL_SEL), .CNT_W(CNT_W), .ADJ_W(ADJ_W), .SEC_W(SEC_W)
    ) u_decode (
        .trim(active_trim), .base_mod(base_mod), .win_len(win_len),
        .shorten_cnt(shorten_cnt), .lengthen_cnt(lengthen_cnt)
    );

    rtc_trim_window #(.SEC_W(SEC_W)) u_window (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .staged_trim(staged_q),
        .win_len(win_len), .active_trim(active_trim), .last_sec(last_sec)
    );

    rtc_trim_divider #(.CNT_W(CNT_W), .ADJ_W(ADJ_W)) u_divider (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .base_mod(base_mod),
        .shorten_cnt(shorten_cnt), .lengthen_cnt(lengthen_cnt),
        .last_sec(last_sec), .wrap(wrap), .tick(sec_tick)
    );

    AST_NO_ADJ_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_trim.field[5:1] == 5'd0) |->
            (shorten_cnt == '0 && lengthen_cnt == '0));              // R3
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(shorten_cnt != '0 && lengthen_cnt != '0));                 // R4

endmodule

// File: tb/rtc_trim_prescaler_tb.sv
// Bench: two variants on shared stimulus, with directed and seeded random trims.
module rtc_trim_prescaler_tb;

    localparam int TB_OSC  = 150;
    localparam int TB_ALT  = 140;
    localparam int TB_WIN  = 3;
    localparam int TB_FINE = 2;
    localparam int TB_STEP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       trim_we = 1'b0;
    logic [7:0] trim_wdata = 8'h00;
    logic       tick_f, tick_a;
    bit         osc_run = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int r1_bad = 0;

    always #2 clk = ~clk;

    rtc_trim_prescaler #(.OSC_HZ(TB_OSC), .ALT_HZ(TB_ALT), .WIN_SECS(TB_WIN),
        .FINE_MULT(TB_FINE), .STEP_CNT(TB_STEP), .CRYSTAL_SEL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .trim_we(trim_we),
        .trim_wdata(trim_wdata), .sec_tick(tick_f));

    rtc_trim_prescaler #(.OSC_HZ(TB_OSC), .ALT_HZ(TB_ALT), .WIN_SECS(TB_WIN),
        .FINE_MULT(TB_FINE), .STEP_CNT(TB_STEP), .CRYSTAL_SEL(1'b1)) u_alt (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .trim_we(trim_we),
        .trim_wdata(trim_wdata), .sec_tick(tick_a));

    // Randomly gapped oscillator strobe.
    always @(negedge clk)
        osc_en <= osc_run ? (($urandom % 4) != 0) : 1'b0;

    // Measured second lengths in accepted oscillator counts.
    int q_f[$];
    int q_a[$];
    int n_f = 0, n_a = 0;
    logic prev_f = 1'b0, prev_a = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            n_f <= 0; n_a <= 0; prev_f <= 1'b0; prev_a <= 1'b0;
        end else begin
            if (tick_f) begin q_f.push_back(n_f); n_f <= osc_en ? 1 : 0; end
            else if (osc_en) n_f <= n_f + 1;
            if (tick_a) begin q_a.push_back(n_a); n_a <= osc_en ? 1 : 0; end
            else if (osc_en) n_a <= n_a + 1;
            if ((tick_f && prev_f) || (tick_a && prev_a)) r1_bad = r1_bad + 1;
            prev_f <= tick_f;
            prev_a <= tick_a;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Signed step count from the requirements R3, R4 and R5.
    function automatic int steps_of(input logic [7:0] t);
        int f;
        f = int'(t[5:0]);
        if (t[5:1] == 5'd0) return 0;
        if (!t[6]) return f - 1;
        return -(((~f) & 63) + 1);
    endfunction

    function automatic int base_of(input bit alt, input logic [7:0] t);
        return (alt && t[7]) ? TB_ALT : TB_OSC;
    endfunction

    function automatic int win_of(input bit alt, input logic [7:0] t);
        return (!alt && t[7]) ? TB_WIN * TB_FINE : TB_WIN;
    endfunction

    task automatic build(input bit alt, input logic [7:0] a, input logic [7:0] b,
                         input bit use_b, ref int e[$], ref string tg[$]);
        logic [7:0] w [3];
        int nw;
        w[0] = 8'h00; w[1] = a; w[2] = b;
        nw = use_b ? 3 : 2;
        e.delete(); tg.delete();
        for (int wi = 0; wi < nw; wi++) begin
            for (int k = 0; k < win_of(alt, w[wi]); k++) begin
                bit last;
                int s;
                last = (k == win_of(alt, w[wi]) - 1);
                s = steps_of(w[wi]);
                e.push_back(base_of(alt, w[wi]) - (last ? TB_STEP * s : 0));
                if (wi == 0) tg.push_back("R2");
                else if (wi == 2) tg.push_back("R9");
                else if (last && s > 0) tg.push_back("R4");
                else if (last && s < 0) tg.push_back("R5");
                else if (last) tg.push_back("R3");
                else if (w[wi][7]) tg.push_back(alt ? "R8" : "R7");
                else tg.push_back("R6");
            end
        end
    endtask

    task automatic write_trim(input logic [7:0] v);
        @(negedge clk);
        trim_we = 1'b1; trim_wdata = v;
        @(negedge clk);
        trim_we = 1'b0;
    endtask

    task automatic run_case(input logic [7:0] a, input logic [7:0] b, input bit use_b);
        int ef[$]; int ea[$];
        string tf[$]; string ta[$];
        osc_run = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        q_f.delete(); q_a.delete();
        checks = checks + 1;                          // R1 reset state
        if (tick_f !== 1'b0 || tick_a !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R1 reset: actual %b/%b expected 0/0", tick_f, tick_a);
        end
        rst_n = 1'b1; osc_run = 1'b1;
        write_trim(a);
        build(1'b0, a, b, use_b, ef, tf);
        build(1'b1, a, b, use_b, ea, ta);
        if (use_b) begin
            while (q_f.size() < TB_WIN + 1) @(negedge clk);
            write_trim(b);
        end
        while (q_f.size() < ef.size() || q_a.size() < ea.size()) @(negedge clk);
        foreach (ef[i]) begin
            checks = checks + 1;
            if (q_f[i] != ef[i]) begin
                errors = errors + 1;
                $display("FAIL %s fine trim %h/%h sec %0d: actual %0d expected %0d",
                         tf[i], a, b, i, q_f[i], ef[i]);
            end
        end
        foreach (ea[i]) begin
            checks = checks + 1;
            if (q_a[i] != ea[i]) begin
                errors = errors + 1;
                $display("FAIL %s xtal trim %h/%h sec %0d: actual %0d expected %0d",
                         ta[i], a, b, i, q_a[i], ea[i]);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        run_case(8'h00, 8'h00, 1'b0);   // R3 zero
        run_case(8'h01, 8'h00, 1'b0);   // R3 bit 0 alone
        run_case(8'h40, 8'h00, 1'b0);   // R3 direction bit alone
        run_case(8'h41, 8'h00, 1'b0);   // R3 both
        run_case(8'h02, 8'h00, 1'b0);   // R4 one step
        run_case(8'h3F, 8'h00, 1'b0);   // R4 62 steps
        run_case(8'h7F, 8'h00, 1'b0);   // R5 one step
        run_case(8'h42, 8'h00, 1'b0);   // R5 62 steps
        run_case(8'h80, 8'h00, 1'b0);   // R7 R8 mode, no adjust
        run_case(8'hBF, 8'h00, 1'b0);   // R7 R8 mode, +62
        run_case(8'hC2, 8'h00, 1'b0);   // R7 R8 mode, -62
        run_case(8'h05, 8'h7A, 1'b1);   // R9 write partway through window
        for (int r = 0; r < 22; r++) begin
            logic [7:0] t;
            t = 8'($urandom);
            run_case(t, 8'h00, 1'b0);
        end
        checks = checks + 1;                          // R1 tick width
        if (r1_bad != 0) begin
            errors = errors + 1;
            $display("FAIL R1 tick width: actual %0d long ticks expected 0", r1_bad);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule